// File: doc/BRIEF.md
# Opcode Class Decoder with Conditional Skip

This block turns one 8-bit instruction byte of a small accumulator machine into the control fields that a microcode sequencer consumes. It names the instruction class in a one-hot vector, pulls out the two-bit operand selector and the three-bit function field, and builds a wide immediate from whichever bit field the class carries. For the conditional skip instructions it also evaluates the carry and zero flags and states whether the next instruction is to be skipped.

The opcode space has regions that overlap. A push of the instruction pointer sits inside the ALU region and wins over it. The flag-test slot also holds invert-accumulator and two holes. Any byte that maps to nothing drives every output to all ones, so the sequencer sees a fixed and recognisable pattern. A registered stage captures the decode when `load_en` is high and holds it otherwise. A parameter can remove that stage and leave a purely combinational path.

Top module: `opdec_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, until the first load, every output is zero.
- R2: With `load_en` high at a rising edge, the outputs show the decode of `opcode`, `cf` and `zf` sampled at that edge. With `load_en` low, the outputs keep their previous values.
- R3: Bytes `00xxxxxx` give class bit 0 (relative jump) and `imm` equal to the six-bit field sign-extended to `IMM_W` bits. Byte 0x00 therefore gives `imm` = 0.
- R4: Bytes `01xxxxxx` give class bit 1 (add immediate to accumulator) and `imm` equal to the sign-extended six-bit field, in the range -32 to +31.
- R5: Bytes `10000xxx` give class bit 2 (push instruction pointer) and `imm` equal to the three-bit field zero-extended. They never report class bit 3.
- R6: Bytes `100ssyyy` with ss not 00 and yyy not 000 give class bit 3 (ALU). `opsel` equals ss (01 = U, 10 = V, 11 = memory at the pointer) and `func` equals yyy.
- R7: Bytes `101xxxxx` give class bit 4 (pointer subtract) and bytes `110xxxxx` give class bit 5 (pointer add). In both, `imm` equals x+1, which lies in the range 1 to 32.
- R8: Bytes `11100yyy` give class bit 6 (register load, store or swap), `11101yyy` give class bit 7 (register move) and `11111yyy` give class bit 10 (stack and long operations). In each of these, `func` equals yyy.
- R9: Bytes `11110bbb` with b2 not equal to b1 give class bit 8 (skip) and `func` = bbb. `skip_take` is (b1 ? cf : zf) XOR b0: b1 picks carry, b2 picks zero and b0 inverts the flag.
- R10: Bytes 0xF0 and 0xF6 give class bit 9 (invert accumulator) with `skip_take` low.
- R11: Bytes `100ss000` with ss not 00, and bytes 0xF1 and 0xF7, are undefined. They drive `op_class`, `opsel`, `func`, `imm`, `undef` and `skip_take` all to ones.
- R12: For every defined byte, `op_class` has exactly one bit set, `undef` is low and `skip_take` is low outside the skip class. Fields that a class does not use read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Capture the decode of the present byte |
| opcode | input | 8 | Instruction byte |
| cf | input | 1 | Carry flag |
| zf | input | 1 | Zero flag |
| op_class | output | 11 | One-hot instruction class, all ones if undefined |
| opsel | output | 2 | Register operand selector for ALU class |
| func | output | 3 | Function / sub-operation field |
| imm | output | IMM_W (16) | Immediate value |
| undef | output | 1 | Undefined opcode |
| skip_take | output | 1 | Conditional skip is taken |

## Verification
All 256 opcode bytes are swept, each with random carry and zero flags, so that every region boundary is crossed. The sweep separates the push slot from the ALU slot, the skip slot from invert-accumulator and from the holes, and the sign-extended immediates from the magnitude immediates. A directed pass runs every skip byte under all four flag combinations, which tells flag selection apart from inversion. A random phase with `load_en` toggling confirms that the captured values are held between loads.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OP_W  = 8;
  localparam int CLS_W = 11;

  localparam int C_JREL  = 0;
  localparam int C_ADDI  = 1;
  localparam int C_PUSH  = 2;
  localparam int C_ALU   = 3;
  localparam int C_PSUB  = 4;
  localparam int C_PADD  = 5;
  localparam int C_XFER  = 6;
  localparam int C_MOVE  = 7;
  localparam int C_SKIP  = 8;
  localparam int C_INVA  = 9;
  localparam int C_STACK = 10;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [1:0]       opsel;
    logic [2:0]       func;
    logic             undef;
  } dec_t;
endpackage

// File: rtl/opdec_class.sv
module opdec_class
  import opdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '0;
    casez (op)
      8'b00??????: dec.cls[C_JREL] = 1'b1;
      8'b01??????: dec.cls[C_ADDI] = 1'b1;
      8'b10000???: dec.cls[C_PUSH] = 1'b1;
      8'b100?????: begin
        if (op[2:0] == 3'b000) begin
          dec.undef = 1'b1;
        end else begin
          dec.cls[C_ALU] = 1'b1;
          dec.opsel      = op[4:3];
          dec.func       = op[2:0];
        end
      end
      8'b101?????: dec.cls[C_PSUB] = 1'b1;
      8'b110?????: dec.cls[C_PADD] = 1'b1;
      8'b11100???: begin
        dec.cls[C_XFER] = 1'b1;
        dec.func        = op[2:0];
      end
      8'b11101???: begin
        dec.cls[C_MOVE] = 1'b1;
        dec.func        = op[2:0];
      end
      8'b11110???: begin
        if (op[2] != op[1]) begin
          dec.cls[C_SKIP] = 1'b1;
          dec.func        = op[2:0];
        end else if (!op[0]) begin
          dec.cls[C_INVA] = 1'b1;
        end else begin
          dec.undef = 1'b1;
        end
      end
      default: begin
        dec.cls[C_STACK] = 1'b1;
        dec.func         = op[2:0];
      end
    endcase
  end

  // R12: a defined byte selects exactly one class
  always_comb begin
    a_r12_class_onehot: assert (dec.undef || $countones(dec.cls) == 1);
  end
endmodule

// File: rtl/opdec_imm.sv
module opdec_imm
  import opdec_pkg::*;
#(
  parameter int IMM_W = 16
) (
  input  logic [5:0]       field,
  input  logic [CLS_W-1:0] cls,
  output logic [IMM_W-1:0] imm
);
  localparam int PAD6 = IMM_W - 6;
  localparam int PAD3 = IMM_W - 3;

  logic [IMM_W-1:0] sext6;
  logic [IMM_W-1:0] zext3;
  logic [IMM_W-1:0] mag;
  logic [5:0]       mag6;

  assign mag6  = {1'b0, field[4:0]} + 6'd1;
  assign sext6 = {{PAD6{field[5]}}, field};
  assign zext3 = {{PAD3{1'b0}}, field[2:0]};
  assign mag   = {{PAD6{1'b0}}, mag6};

  always_comb begin
    imm = '0;
    if (cls[C_JREL] || cls[C_ADDI]) imm = sext6;
    else if (cls[C_PUSH])           imm = zext3;
    else if (cls[C_PSUB] || cls[C_PADD]) imm = mag;
  end

  // R7: magnitude immediates never read zero
  always_comb begin
    a_r7_mag_nonzero: assert (!(cls[C_PSUB] || cls[C_PADD]) || (imm != '0));
  end
endmodule

// File: rtl/opdec_skip.sv
module opdec_skip (
  input  logic       is_skip,
  input  logic [2:0] sel,
  input  logic       cf,
  input  logic       zf,
  output logic       take
);
  logic picked;

  always_comb begin
    picked = sel[1] ? cf : zf;
    take   = is_skip & (picked ^ sel[0]);
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int IMM_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cf,
  input  logic              zf,
  output logic [CLS_W-1:0]  op_class,
  output logic [1:0]        opsel,
  output logic [2:0]        func,
  output logic [IMM_W-1:0]  imm,
  output logic              undef,
  output logic              skip_take
);
  localparam int VEC_W = CLS_W + 2 + 3 + IMM_W + 2;

  dec_t             dec;
  logic [IMM_W-1:0] imm_raw;
  logic             take_raw;
  logic [VEC_W-1:0] vec_d;
  logic [VEC_W-1:0] vec_q;

  opdec_class u_class (
    .op  (opcode),
    .dec (dec)
  );

  opdec_imm #(.IMM_W(IMM_W)) u_imm (
    .field (opcode[5:0]),
    .cls   (dec.cls),
    .imm   (imm_raw)
  );

  opdec_skip u_skip (
    .is_skip (dec.cls[C_SKIP]),
    .sel     (opcode[2:0]),
    .cf      (cf),
    .zf      (zf),
    .take    (take_raw)
  );

  always_comb begin
    if (dec.undef) vec_d = '1;
    else           vec_d = {dec.cls, dec.opsel, dec.func, imm_raw, 1'b0, take_raw};
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [VEC_W-1:0] vec_nxt;

      always_comb begin
        vec_nxt = vec_q;
        if (load_en) vec_nxt = vec_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_nxt;
      end

      // R2: outputs hold while no load is requested
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(vec_q));
    end else begin : g_comb
      assign vec_q = vec_d;
    end
  endgenerate

  assign {op_class, opsel, func, imm, undef, skip_take} = vec_q;

  // R11: an undefined byte drives every field to ones
  a_r11_undef_ones: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (&op_class && &opsel && &func && &imm && skip_take));

  // R12: a defined, loaded byte has a one-hot class
  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (!undef && op_class != '0) |-> $countones(op_class) == 1);

  // R9: a skip is only taken by the skip class
  a_r9_skip_class: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_take && !undef) |-> op_class[C_SKIP]);

  // R5: the ALU class never carries operand selector 00
  a_r5_push_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class[C_ALU] && !undef) |-> opsel != 2'b00);
endmodule

// File: tb/sim_opdec_top.sv
module sim_opdec_top;
  localparam int IMM_W = 16;
  localparam int VEC_W = 11 + 2 + 3 + IMM_W + 2;

  logic              clk;
  logic              rst_n;
  logic              load_en;
  logic [7:0]        opcode;
  logic              cf;
  logic              zf;
  logic [10:0]       op_class;
  logic [1:0]        opsel;
  logic [2:0]        func;
  logic [IMM_W-1:0]  imm;
  logic              undef;
  logic              skip_take;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [VEC_W-1:0] held;

  opdec_top #(.IMM_W(IMM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .opcode(opcode),
    .cf(cf), .zf(zf), .op_class(op_class), .opsel(opsel), .func(func),
    .imm(imm), .undef(undef), .skip_take(skip_take)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [VEC_W-1:0] ref_vec(input logic [7:0] op, input logic c, input logic z);
    logic [10:0] k;
    logic [1:0]  s;
    logic [2:0]  f;
    logic [IMM_W-1:0] im;
    logic tk;
    bit bad;
    k = '0; s = '0; f = '0; im = '0; tk = 1'b0; bad = 0;
    if (op[7:6] == 2'b00) begin
      k[0] = 1; im = IMM_W'($signed(op[5:0]));
    end else if (op[7:6] == 2'b01) begin
      k[1] = 1; im = IMM_W'($signed(op[5:0]));
    end else if (op[7:5] == 3'b100) begin
      if (op[4:3] == 2'b00) begin
        k[2] = 1; im = IMM_W'(op[2:0]);
      end else if (op[2:0] == 3'b000) bad = 1;
      else begin
        k[3] = 1; s = op[4:3]; f = op[2:0];
      end
    end else if (op[7:5] == 3'b101) begin
      k[4] = 1; im = IMM_W'(op[4:0]) + 1;
    end else if (op[7:5] == 3'b110) begin
      k[5] = 1; im = IMM_W'(op[4:0]) + 1;
    end else if (op[7:3] == 5'b11100) begin
      k[6] = 1; f = op[2:0];
    end else if (op[7:3] == 5'b11101) begin
      k[7] = 1; f = op[2:0];
    end else if (op[7:3] == 5'b11110) begin
      if (op == 8'hF0 || op == 8'hF6) k[9] = 1;
      else if (op == 8'hF1 || op == 8'hF7) bad = 1;
      else begin
        k[8] = 1; f = op[2:0];
        tk = (op[1] ? c : z) ^ op[0];
      end
    end else begin
      k[10] = 1; f = op[2:0];
    end
    if (bad) return '1;
    return {k, s, f, im, 1'b0, tk};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op == 8'h81 || op == 8'h88 && 0) return "R6";
    if (op[7:6] == 2'b00) return "R3";
    if (op[7:6] == 2'b01) return "R4";
    if (op[7:3] == 5'b10000) return "R5";
    if (op[7:5] == 3'b100) return (op[2:0] == 0) ? "R11" : "R6";
    if (op[7:5] == 3'b101 || op[7:5] == 3'b110) return "R7";
    if (op == 8'hF1 || op == 8'hF7) return "R11";
    if (op == 8'hF0 || op == 8'hF6) return "R10";
    if (op[7:3] == 5'b11110) return "R9";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [VEC_W-1:0] exp);
    logic [VEC_W-1:0] act;
    act = {op_class, opsel, func, imm, undef, skip_take};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h actual=%h expected=%h", tag, opcode, act, exp);
    end
    if (exp != '1 && act[VEC_W-1 -: 11] != '0 && $countones(act[VEC_W-1 -: 11]) != 1) begin
      errors++;
      $display("FAIL R12 op=%h actual class=%h expected one-hot", opcode, act[VEC_W-1 -: 11]);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic c, input logic z, input logic en);
    @(negedge clk);
    opcode = op; cf = c; zf = z; load_en = en;
    if (en) held = ref_vec(op, c, z);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0D1C_5EED);
    rst_n = 1'b0; load_en = 1'b0; opcode = 8'hFF; cf = 1'b1; zf = 1'b1;
    held = '0;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // full sweep with random flags (R2 capture path, R3..R12 by region)
    for (int i = 0; i < 256; i++) begin
      apply(8'(i), 1'($urandom), 1'($urandom), 1'b1);
      check(tag_of(8'(i)), held);
    end

    // skip bytes under all four flag combinations (R9)
    for (int b = 0; b < 8; b++) begin
      for (int fl = 0; fl < 4; fl++) begin
        apply(8'hF0 | 8'(b), fl[1], fl[0], 1'b1);
        check(tag_of(8'hF0 | 8'(b)), held);
      end
    end

    // directed corners: no-op, extremes of immediates, push priority
    apply(8'h00, 1'b0, 1'b0, 1'b1); check("R3", {11'h001, 2'b0, 3'b0, 16'h0000, 2'b0});
    apply(8'h20, 1'b0, 1'b0, 1'b1); check("R3", {11'h001, 2'b0, 3'b0, 16'hFFE0, 2'b0});
    apply(8'h5F, 1'b0, 1'b0, 1'b1); check("R4", {11'h002, 2'b0, 3'b0, 16'h001F, 2'b0});
    apply(8'h87, 1'b1, 1'b1, 1'b1); check("R5", {11'h004, 2'b0, 3'b0, 16'h0007, 2'b0});
    apply(8'hBF, 1'b0, 1'b0, 1'b1); check("R7", {11'h010, 2'b0, 3'b0, 16'h0020, 2'b0});
    apply(8'hC0, 1'b0, 1'b0, 1'b1); check("R7", {11'h020, 2'b0, 3'b0, 16'h0001, 2'b0});
    apply(8'h98, 1'b0, 1'b0, 1'b1); check("R11", '1);

    // random loads and holds (R2)
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      op = 8'($urandom);
      apply(op, 1'($urandom), 1'($urandom), 1'($urandom));
      check("R2", held);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule